// File: doc/BRIEF.md
# Event Flag and Wakeup Combiner

This block gathers the interrupt sources of a calendar timer into one place. Five periodic carry strobes arrive from the time counters: sub-second tick, second, minute, hour and day. A single-cycle alarm pulse and a raw external wakeup pin come in as well. Each enabled source latches into its own sticky bit of a flag word. Software reads the flag word and clears bits by writing ones.

One level interrupt request is raised while the global enable is on and any flag is pending. A separate wakeup request tells a clock gater to turn clocks back on. It is driven by the synchronised wakeup pin level, or by any pending alarm or periodic flag. The pin only counts while its direction input marks it as an input.

The wakeup pin passes through a two-flop synchroniser. Its rising edge sets the external flag. Its level drives the wakeup request.

Top module: `evt_wake_top`

## Requirements
- R1: After reset the flag word is 0, the interrupt request is 0, and the wakeup request is 0 while the pin is low.
- R2: A strobe on periodic input i (bit 0 tick, 1 second, 2 minute, 3 hour, 4 day) with enable bit i set sets flag bit i at the next clock edge. The strobe has no effect on the flag word when its enable bit is 0.
- R3: An alarm pulse sets flag bit 15 at the next clock edge when enable bit 15 is 1, and has no effect otherwise.
- R4: A set flag stays set until a clear write has a 1 in that bit position. Clear-write bits that are 0 leave their flags unchanged.
- R5: When an event and a clear of the same flag bit fall in the same cycle, the flag is set after that edge.
- R6: The interrupt request is 1 exactly while the global enable is 1 and at least one flag bit is 1, with no added cycle of delay.
- R7: A rising edge of the wakeup pin sets flag bit 8 at the third clock edge after the pin rises. This happens only when the direction input is 0 (pin is an input) and the external enable is 1. A pin held high sets the flag only once.
- R8: The wakeup request follows the pin level two clock edges after the pin changes, while the direction input is 0. This holds whatever the external enable and flag state are. With the direction input at 1 the pin does not drive the request.
- R9: The wakeup request is 1 while any of flag bits 0 to 4 or 15 is set.
- R10: Flag bits 5 to 7 and 9 to 14 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| per_strobe_i | input | 5 | Periodic carry strobes: tick, second, minute, hour, day |
| alarm_i | input | 1 | Alarm match pulse |
| wake_pin_i | input | 1 | Raw external wakeup pin, asynchronous |
| wake_dir_i | input | 1 | Pin direction, 0 = input, 1 = output |
| src_en_i | input | 16 | Source enables: bits 0-4 periodic, bit 15 alarm |
| ext_en_i | input | 1 | External wakeup source enable |
| irq_en_i | input | 1 | Global interrupt enable |
| clr_we_i | input | 1 | Flag clear write strobe |
| clr_data_i | input | 16 | Write-one-to-clear mask |
| flags_o | output | 16 | Sticky flag word |
| irq_o | output | 1 | Level interrupt request |
| wake_o | output | 1 | Clock ungate request |

## Verification
Suppose a flag register loses or gains a bit. The error shows on flags_o at the next sample, and through irq_o and wake_o in the same cycle. A flag that was not cleared stays wrong until a clear write has a 1 in that bit position. A fault in the synchroniser or the edge detector changes when the external flag appears, counted against the three-edge delay after the pin rises. It can also make the flag set twice while the pin is held high. Alongside directed corner cases, random traffic checks every output in every cycle against a model built from the requirements.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int FLAG_W    = 16;
    localparam int NPER      = 5;
    localparam int ALARM_BIT = 15;
    localparam int EXT_BIT   = 8;
    localparam int SYNC_N    = 2;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } flag_state_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin_i};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = st_q.chain[STAGES-1] & ~st_q.last;

    // R7
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/flag_bank.sv
module flag_bank
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_vec_i,
    input  logic              clr_we_i,
    input  logic [FLAG_W-1:0] clr_data_i,
    output logic [FLAG_W-1:0] flags_o
);
    flag_state_t st_d, st_q;
    logic [FLAG_W-1:0] clr_mask;

    always_comb begin
        clr_mask = clr_we_i ? clr_data_i : '0;
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_mask) | set_vec_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & $past(flags_o & ~clr_mask)) == $past(flags_o & ~clr_mask)));
    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & $past(clr_mask & ~set_vec_i)) == '0));
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & $past(set_vec_i)) == $past(set_vec_i)));
endmodule

// File: rtl/evt_wake_top.sv
module evt_wake_top
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPER-1:0]   per_strobe_i,
    input  logic              alarm_i,
    input  logic              wake_pin_i,
    input  logic              wake_dir_i,
    input  logic [FLAG_W-1:0] src_en_i,
    input  logic              ext_en_i,
    input  logic              irq_en_i,
    input  logic              clr_we_i,
    input  logic [FLAG_W-1:0] clr_data_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              irq_o,
    output logic              wake_o
);
    localparam logic [FLAG_W-1:0] EVT_MASK =
        (FLAG_W'(1) << ALARM_BIT) | FLAG_W'((1 << NPER) - 1);
    localparam logic [FLAG_W-1:0] RSVD_MASK = ~(EVT_MASK | (FLAG_W'(1) << EXT_BIT));

    logic              pin_level, pin_rise, pin_is_in;
    logic [FLAG_W-1:0] set_vec;

    wake_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (wake_pin_i),
        .level_o (pin_level),
        .rise_o  (pin_rise)
    );

    assign pin_is_in = ~wake_dir_i;

    always_comb begin
        set_vec            = '0;
        set_vec[ALARM_BIT] = alarm_i & src_en_i[ALARM_BIT];
        set_vec[EXT_BIT]   = pin_rise & pin_is_in & ext_en_i;
        for (int i = 0; i < NPER; i++) begin
            set_vec[i] = per_strobe_i[i] & src_en_i[i];
        end
    end

    flag_bank u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec_i  (set_vec),
        .clr_we_i   (clr_we_i),
        .clr_data_i (clr_data_i),
        .flags_o    (flags_o)
    );

    assign irq_o  = irq_en_i & (|flags_o);
    assign wake_o = (pin_level & pin_is_in) | (|(flags_o & EVT_MASK));

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & RSVD_MASK) == '0);
    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en_i && flags_o != '0));
    // R9
    wake_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & EVT_MASK) != '0) |-> wake_o);
    // R2
    per_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_o[0] && !src_en_i[0] && !(clr_we_i && clr_data_i[0])) |=> !flags_o[0]);
endmodule

// File: tb/evt_wake_top_test.sv
module evt_wake_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  per_strobe_i = '0;
    logic        alarm_i = 1'b0, wake_pin_i = 1'b0, wake_dir_i = 1'b0;
    logic [15:0] src_en_i = '0;
    logic        ext_en_i = 1'b0, irq_en_i = 1'b0, clr_we_i = 1'b0;
    logic [15:0] clr_data_i = '0;
    logic [15:0] flags_o;
    logic        irq_o, wake_o;

    int checks = 0, fails = 0;
    logic [15:0] m_flags = '0;
    logic        m_p1 = 0, m_p2 = 0, m_p3 = 0;

    always #10 clk = ~clk;

    evt_wake_top uut (.*);

    function automatic logic [15:0] next_flags(
        input logic [15:0] f, input logic [4:0] s, input logic al,
        input logic [15:0] en, input logic rise, input logic dir,
        input logic xen, input logic we, input logic [15:0] cd);
        logic [15:0] setv = '0;
        for (int i = 0; i < 5; i++) setv[i] = s[i] & en[i];
        setv[15] = al & en[15];
        setv[8]  = rise & ~dir & xen;
        return (f & ~(we ? cd : 16'h0)) | setv;
    endfunction

    function automatic logic exp_wake(input logic [15:0] f, input logic p2, input logic dir);
        return (p2 & ~dir) | (|(f & 16'h801F));
    endfunction

    task automatic chk(input string lbl, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
        end
    endtask

    task automatic step(input string lbl);
        @(posedge clk);
        m_flags = next_flags(m_flags, per_strobe_i, alarm_i, src_en_i, m_p2 & ~m_p3,
                             wake_dir_i, ext_en_i, clr_we_i, clr_data_i);
        m_p3 = m_p2; m_p2 = m_p1; m_p1 = wake_pin_i;
        @(negedge clk);
        per_strobe_i = '0; alarm_i = 0; clr_we_i = 0; clr_data_i = '0;
        chk({lbl, " flags"}, flags_o, m_flags);
        chk({lbl, " R6 irq"}, {15'd0, irq_o}, {15'd0, irq_en_i & (|m_flags)});
        chk({lbl, " wake"}, {15'd0, wake_o}, {15'd0, exp_wake(m_flags, m_p2, wake_dir_i)});
    endtask

    initial begin
        #(20 * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flags", flags_o, 16'h0);
        chk("R1 irq", {15'd0, irq_o}, 16'h0);
        chk("R1 wake", {15'd0, wake_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 disabled strobe ignored
        per_strobe_i = 5'b11111; step("R2 disabled");
        chk("R2 none set", flags_o, 16'h0);
        // R2 each periodic source
        src_en_i = 16'h801F;
        for (int i = 0; i < 5; i++) begin
            per_strobe_i = 5'b1 << i; step("R2 single");
            chk("R2 bit", flags_o, 16'((1 << (i + 1)) - 1));
        end
        // R6 irq gated by global enable
        chk("R6 off", {15'd0, irq_o}, 16'h0);
        irq_en_i = 1; #1;
        chk("R6 on", {15'd0, irq_o}, 16'h1);
        // R9 wake from pending flags
        chk("R9 wake", {15'd0, wake_o}, 16'h1);
        // R4 writing zeros keeps flags
        clr_we_i = 1; clr_data_i = 16'h0; step("R4 zero write");
        chk("R4 kept", flags_o, 16'h001F);
        clr_we_i = 1; clr_data_i = 16'h0001; step("R4 clear one");
        chk("R4 cleared", flags_o, 16'h001E);
        // R5 set beats clear
        per_strobe_i = 5'b00001; clr_we_i = 1; clr_data_i = 16'h0001; step("R5 race");
        chk("R5 set wins", flags_o, 16'h001F);
        // R3 alarm
        alarm_i = 1; step("R3 alarm");
        chk("R3 bit15", flags_o, 16'h801F);
        clr_we_i = 1; clr_data_i = 16'hFFFF; step("R4 clear all");
        chk("R4 empty", flags_o, 16'h0);
        chk("R6 idle", {15'd0, irq_o}, 16'h0);
        src_en_i[15] = 0; alarm_i = 1; step("R3 disabled");
        chk("R3 ignored", flags_o, 16'h0);
        chk("R9 idle", {15'd0, wake_o}, 16'h0);

        // R7 R8 pin edge with input direction
        ext_en_i = 1; wake_pin_i = 1;
        step("R8 edge1");
        chk("R8 not yet", {15'd0, wake_o}, 16'h0);
        step("R8 edge2");
        chk("R8 level", {15'd0, wake_o}, 16'h1);
        chk("R7 not yet", flags_o, 16'h0);
        step("R7 edge3");
        chk("R7 ext flag", flags_o, 16'h0100);
        clr_we_i = 1; clr_data_i = 16'h0100; step("R7 clr");
        repeat (4) step("R7 held");
        chk("R7 once only", flags_o, 16'h0);
        chk("R8 held high", {15'd0, wake_o}, 16'h1);
        wake_pin_i = 0; repeat (3) step("R8 low");
        // R7 R8 output direction ignored
        wake_dir_i = 1; wake_pin_i = 1; repeat (4) step("R7 dir out");
        chk("R7 dir ignored", flags_o, 16'h0);
        chk("R8 dir out", {15'd0, wake_o}, 16'h0);
        wake_pin_i = 0; wake_dir_i = 0; repeat (3) step("R7 settle");
        // R8 ext disabled still wakes
        ext_en_i = 0; wake_pin_i = 1; repeat (4) step("R8 ext off");
        chk("R7 ext off no flag", flags_o, 16'h0);
        chk("R8 wake anyway", {15'd0, wake_o}, 16'h1);
        wake_pin_i = 0;

        // random traffic, also R10 reserved bits via model
        for (int n = 0; n < 3000; n++) begin
            per_strobe_i = ($urandom % 4 == 0) ? 5'($urandom) : 5'h0;
            alarm_i      = ($urandom % 8 == 0);
            if ($urandom % 16 == 0) wake_pin_i = ~wake_pin_i;
            if ($urandom % 64 == 0) wake_dir_i = ~wake_dir_i;
            if ($urandom % 32 == 0) src_en_i = 16'($urandom);
            if ($urandom % 32 == 0) ext_en_i = $urandom;
            if ($urandom % 32 == 0) irq_en_i = $urandom;
            clr_we_i   = ($urandom % 5 == 0);
            clr_data_i = 16'($urandom);
            step("R2 R3 R4 R5 R7 R10 random");
            if ((n % 500) == 0) chk("R10 reserved", flags_o & 16'h7EE0, 16'h0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule